// File: doc/BRIEF.md
# Triple-Copy Configuration Register Bank with Upset Detection

This block holds a small bank of configuration registers in which every stored bit lives in three separate flip-flops. A write through the simple address/data port loads the same value into all three copies. The value returned on a read, and the value driven to the logic that consumes the configuration (`cfg_q`), is the OR of the three copies of each bit. The resolution does not use a majority vote, so a bit that any copy holds as 1 reads as 1.

Comparison logic checks the three copies of every protected bit on every cycle. When any copy disagrees with the others, a sticky configuration-error status bit is set. The status bit drives the `irq` output only while its enable bit is set. Software can set the status bit by hand to test the interrupt path. It clears the status by writing 1 to the enabled-status address. Software restores agreement among the copies by rewriting the affected register. A fault-injection port flips any single copy of any bit, so upsets can be modelled.

Top module: `cfg_tmr_bank`

## Requirements
- R1: After reset, every copy of every protected bit is 0, the error status and its enable are 0, `irq` is 0, and every address reads 0.
- R2: A write to a protected register (addresses 4 to 4+NREGS-1, register k at address 4+k) loads all three copies. Both the read of that address and slice k of `cfg_q` (bits k*DW upward) then return the written data.
- R3: The resolved value of each protected bit is the OR of its three copies. This holds whether one copy or two copies differ from the rest.
- R4: A disagreement among the copies of any protected bit sets the error status (bit 0 at address 0) at the first clock edge after the disagreement appears, and not earlier.
- R5: The error status is sticky. A rewrite of the register makes its copies agree again and reads back the written data, and the status stays set until it is cleared.
- R6: A write with data bit 0 = 1 to address 1 clears the error status, unless a disagreement is present at that same edge, in which case the status stays set.
- R7: A write with data bit 0 = 1 to address 0 sets the error status.
- R8: `irq` is high exactly when both the error status and its enable are set. A write with bit 0 = 1 to address 2 sets the enable, and a write with bit 0 = 1 to address 3 clears it. Both addresses read the enable in bit 0.
- R9: Address 1 reads the error status ANDed with the enable in bit 0.
- R10: Writes to addresses 0 to 3 with data bit 0 = 0 change neither the error status nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | AW | Shared read/write address |
| wdata | input | DW | Write data |
| rdata | output | DW | Combinational read data for `addr` |
| cfg_q | output | NREGS*DW | Resolved values of all protected registers |
| irq | output | 1 | Configuration-error interrupt |
| inj_en | input | 1 | Fault injection strobe: inverts one copy of one bit |
| inj_reg | input | $clog2(NREGS) | Register selected for injection |
| inj_bit | input | $clog2(DW) | Bit selected for injection |
| inj_copy | input | 2 | Copy selected for injection (0 to 2; 3 selects none) |

## Verification
If one copy of a bit is corrupted, the fault shows on `rdata` and `cfg_q` in the same cycle when it turns a 0 into a 1. It is hidden when it turns a 1 into a 0, because the OR still reads 1. In both cases the status bit at address 0 rises exactly one edge later. The bench sweeps every register, bit and copy under both bit polarities. At each point it checks the resolved value and the exact cycle in which the status rises. It then checks that the status survives a rewrite and that a clear removes it. A comparator or an update that fails to touch all three copies therefore shows within one or two cycles of the stimulus.

// File: rtl/cfg_tmr_bank.sv
module cfg_tmr_bank #(
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int NREGS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  output logic [NREGS*DW-1:0]   cfg_q,
  output logic                  irq,
  input  logic                  inj_en,
  input  logic [$clog2(NREGS)-1:0] inj_reg,
  input  logic [$clog2(DW)-1:0] inj_bit,
  input  logic [1:0]            inj_copy
);
  localparam int RW   = $clog2(NREGS);
  localparam int BASE = 4;
  localparam logic [AW-1:0] A_RAW = AW'(0);
  localparam logic [AW-1:0] A_ENS = AW'(1);
  localparam logic [AW-1:0] A_ESET = AW'(2);
  localparam logic [AW-1:0] A_ECLR = AW'(3);

  logic [DW-1:0]    rv [NREGS];
  logic [NREGS-1:0] mm_vec;
  logic             mm_any;
  logic             raw_q, en_q;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [AW-1:0] MY_A = AW'(BASE + g);
    logic [DW-1:0] c0, c1, c2;
    logic wsel, isel;
    assign wsel = wr_en && (addr == MY_A);
    assign isel = inj_en && (inj_reg == RW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c0 <= '0;
        c1 <= '0;
        c2 <= '0;
      end else if (wsel) begin
        c0 <= wdata;
        c1 <= wdata;
        c2 <= wdata;
      end else if (isel) begin
        case (inj_copy)
          2'd0:    c0[inj_bit] <= ~c0[inj_bit];
          2'd1:    c1[inj_bit] <= ~c1[inj_bit];
          2'd2:    c2[inj_bit] <= ~c2[inj_bit];
          default: ;
        endcase
      end
    end

    assign rv[g] = c0 | c1 | c2;
    assign mm_vec[g] = |((c0 ^ c1) | (c1 ^ c2));
    assign cfg_q[g*DW +: DW] = rv[g];
  end

  assign mm_any = |mm_vec;

  logic set_wr, clr_wr, ens_wr, enc_wr;
  assign set_wr = wr_en && (addr == A_RAW)  && wdata[0];
  assign clr_wr = wr_en && (addr == A_ENS)  && wdata[0];
  assign ens_wr = wr_en && (addr == A_ESET) && wdata[0];
  assign enc_wr = wr_en && (addr == A_ECLR) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      raw_q <= mm_any | set_wr | (raw_q & ~clr_wr);
      if (ens_wr)      en_q <= 1'b1;
      else if (enc_wr) en_q <= 1'b0;
    end
  end

  assign irq = raw_q & en_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_RAW:  rdata[0] = raw_q;
      A_ENS:  rdata[0] = raw_q & en_q;
      A_ESET: rdata[0] = en_q;
      A_ECLR: rdata[0] = en_q;
      default:
        for (int i = 0; i < NREGS; i++)
          if (addr == AW'(BASE + i)) rdata = rv[i];
    endcase
  end
endmodule

// File: rtl/cfg_tmr_bank_chk.sv
module cfg_tmr_bank_chk #(
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int NREGS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic             mm_any,
  input logic [NREGS-1:0] mm_vec,
  input logic             raw_q,
  input logic             en_q
);
  logic wset, wclr, wens, wenc;
  assign wset = wr_en && (addr == AW'(0)) && wdata[0];
  assign wclr = wr_en && (addr == AW'(1)) && wdata[0];
  assign wens = wr_en && (addr == AW'(2)) && wdata[0];
  assign wenc = wr_en && (addr == AW'(3)) && wdata[0];

  AST_SET_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n) mm_any |=> raw_q); // R4
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (raw_q && !wclr) |=> raw_q); // R5
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n) (!raw_q && !mm_any && !wset) |=> !raw_q); // R10
  AST_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n) wset |=> raw_q); // R7
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n) wens |=> en_q); // R8
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n) wenc |=> !en_q); // R8

  for (genvar g = 0; g < NREGS; g++) begin : g_agree
    AST_WRITE_AGREES: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == AW'(4 + g)) |=> !mm_vec[g]); // R2
  end
endmodule

bind cfg_tmr_bank cfg_tmr_bank_chk #(.AW(AW), .DW(DW), .NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .mm_any(mm_any), .mm_vec(mm_vec), .raw_q(raw_q), .en_q(en_q)
);

// File: tb/cfg_tmr_bank_tb.sv
`timescale 1ns/1ps
module cfg_tmr_bank_tb;
  localparam int AW = 3, DW = 8, NREGS = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NREGS*DW-1:0] cfg_q;
  logic irq;
  logic inj_en = 0;
  logic [1:0] inj_reg = '0;
  logic [2:0] inj_bit = '0;
  logic [1:0] inj_copy = '0;

  int n_tests = 0, n_fail = 0, cyc = 0;

  cfg_tmr_bank #(.AW(AW), .DW(DW), .NREGS(NREGS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cfg_q(cfg_q), .irq(irq), .inj_en(inj_en),
    .inj_reg(inj_reg), .inj_bit(inj_bit), .inj_copy(inj_copy)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic inj(input int r, input int b, input int c);
    @(negedge clk);
    inj_en = 1; inj_reg = 2'(r); inj_bit = 3'(b); inj_copy = 2'(c);
    @(negedge clk);
    inj_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    addr = AW'(a);
    #1;
    v = int'(rdata);
  endtask

  initial begin
    int v, p, e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int a = 0; a < 8; a++) begin
      rd(a, v); chk("R1 reset read", v, 0);
    end
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset cfg_q", int'(cfg_q), 0);

    wr(0, 1);
    rd(0, v); chk("R7 soft set", v, 1);
    chk("R8 irq off while disabled", int'(irq), 0);
    rd(1, v); chk("R9 masked status", v, 0);
    wr(2, 1);
    rd(2, v); chk("R8 enable readback addr2", v, 1);
    rd(3, v); chk("R8 enable readback addr3", v, 1);
    chk("R8 irq on", int'(irq), 1);
    rd(1, v); chk("R9 enabled status", v, 1);
    wr(0, 8'hFE); wr(1, 8'hFE); wr(2, 8'hFE); wr(3, 8'hFE);
    rd(0, v); chk("R10 bit0 clear writes ignored status", v, 1);
    rd(2, v); chk("R10 bit0 clear writes ignored enable", v, 1);
    wr(3, 1);
    chk("R8 irq off after disable", int'(irq), 0);
    rd(2, v); chk("R8 enable cleared", v, 0);
    wr(1, 1);
    rd(0, v); chk("R6 clear status", v, 0);
    wr(0, 8'hFE);
    rd(0, v); chk("R10 no set on bit0 zero", v, 0);
    wr(2, 8'hFE);
    rd(2, v); chk("R10 no enable on bit0 zero", v, 0);

    for (int pol = 0; pol < 2; pol++)
      for (int r = 0; r < NREGS; r++)
        for (int b = 0; b < DW; b++)
          for (int c = 0; c < 3; c++) begin
            p = (r * 53 + b * 29 + c * 7 + 3) & 255;
            if (pol == 1) p = (~p) & 255;
            e = p | (1 << b);
            wr(4 + r, p);
            rd(4 + r, v); chk("R2 write readback", v, p);
            inj(r, b, c);
            rd(4 + r, v); chk("R3 single copy OR", v, e);
            chk("R3 cfg_q OR", int'(cfg_q[r*DW +: DW]), e);
            rd(0, v); chk("R4 not before edge", v, 0);
            @(negedge clk);
            rd(0, v); chk("R4 status after edge", v, 1);
            wr(4 + r, p);
            rd(4 + r, v); chk("R5 rewrite restores", v, p);
            rd(0, v); chk("R5 sticky after rewrite", v, 1);
            wr(1, 1);
            rd(0, v); chk("R6 clear after rewrite", v, 0);
          end

    wr(5, 0);
    inj(1, 2, 0); inj(1, 2, 1);
    rd(5, v); chk("R3 two copies set", v, 4);
    rd(0, v); chk("R4 double flip status", v, 1);
    wr(5, 8'hFF);
    wr(1, 1);
    inj(1, 5, 0); inj(1, 5, 2);
    rd(5, v); chk("R3 two copies cleared", v, 8'hFF);
    wr(1, 1);
    rd(0, v); chk("R6 clear blocked by mismatch", v, 1);
    wr(5, 8'hFF);
    wr(1, 1);
    rd(0, v); chk("R6 clear after repair", v, 0);

    wr(2, 1);
    inj(3, 7, 1);
    chk("R8 irq not yet", int'(irq), 0);
    @(negedge clk);
    chk("R8 irq from mismatch", int'(irq), 1);
    rd(1, v); chk("R9 enabled status mismatch", v, 1);
    wr(7, 0); wr(1, 1);
    chk("R8 irq cleared", int'(irq), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule